// File: doc/BRIEF.md
# CPU Bus Cycle Classifier

This block watches the external bus of an 8-bit processor with a 16-bit address space. On every clock where the sample enable is high it takes one sample of five active-low strobes, the data byte and the address. These strobes are machine-cycle-one, read, write, memory request and I/O request. A fixed priority decode turns the strobes into one of seven bus activity kinds, and the block compares that kind with the kind seen on the previous enabled sample.

A move from no activity to an active kind opens a cycle and latches the address. While the cycle stays active, every enabled sample refreshes a data latch. A move back to no activity closes the cycle and emits one event. The event carries the kind, a coarse access class, the latched address and the data byte from the last active sample. A jump straight from one active kind to a different active kind is flagged as a protocol error. The open capture is then thrown away, so no event comes out for it.

Top module: `bus_cycle_monitor`

## Requirements
- R1: A synchronous active-high reset clears all outputs, sets the remembered kind to "none" and drops any open capture. The first enabled idle sample after reset therefore produces no close marker and no event.
- R2: With memory request low, read low gives kind 1 (opcode fetch) when machine-cycle-one is low and kind 2 (memory read) otherwise. With read high and write low it gives kind 3 (memory write). Read is checked before write.
- R3: With memory request high and I/O request low, machine-cycle-one low gives kind 4 (interrupt acknowledge), whatever read and write show. Failing that, read low gives kind 5 (I/O read), and failing that, write low gives kind 6 (I/O write).
- R4: Memory request is examined before I/O request. Every other strobe combination, including memory request low with neither read nor write low, is kind 0 (none).
- R5: An enabled sample whose kind is active while the remembered kind is none raises `cyc_start_o` for one clock and latches the address of that sample. Address changes on later samples of the same cycle are not captured.
- R6: The data latch is reloaded on every enabled active sample. The event reports the value from the last active sample before the cycle closed.
- R7: An enabled idle sample after an active kind raises `cyc_end_o` for one clock. If the capture is still open, `ev_valid_o` pulses in the same clock with `ev_kind_o`, `ev_addr_o` and `ev_data_o`.
- R8: An enabled sample whose active kind differs from a different remembered active kind raises `illegal_o` for one clock and discards the open capture. The close that follows raises `cyc_end_o` but no event.
- R9: `ev_class_o` encodes 0 memory read, 1 memory write, 2 I/O read, 3 I/O write. A fetch reports class 0 and an interrupt acknowledge reports class 2.
- R10: On clocks with `smp_en` low no sample is taken. Marker and event outputs stay low, and the remembered kind and the latches keep their values.
- R11: All markers and the event appear in the clock after the edge that takes the enabled sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Take a bus sample on this clock |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| data_i | input | 8 | Data bus |
| addr_i | input | 16 | Address bus |
| cyc_start_o | output | 1 | One-clock pulse: a cycle opened |
| cyc_end_o | output | 1 | One-clock pulse: a cycle closed |
| illegal_o | output | 1 | One-clock pulse: active kind changed directly |
| ev_valid_o | output | 1 | One-clock pulse: event fields valid |
| ev_kind_o | output | 3 | Kind of the closed cycle (0..6) |
| ev_class_o | output | 2 | Access class of the closed cycle |
| ev_addr_o | output | 16 | Address latched at cycle open |
| ev_data_o | output | 8 | Data from the last active sample |

## Verification
The assertions assume that the strobes, address and data are already synchronous to `clk` and hold defined values on every enabled sample. They also assume that reset is high on the first clock edge. The stimulus respects this: every input changes only on the falling edge, the strobes are driven as complete defined patterns from a vector table, and reset is applied from time zero. Outputs are read on the falling edge that follows each sampling edge. One directed sequence toggles `smp_en` in the middle of a cycle, and another resets while a cycle is open.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

    localparam int KIND_W  = 3;
    localparam int CLASS_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_NONE    = 3'd0,
        KIND_FETCH   = 3'd1,
        KIND_MEM_RD  = 3'd2,
        KIND_MEM_WR  = 3'd3,
        KIND_INT_ACK = 3'd4,
        KIND_IO_RD   = 3'd5,
        KIND_IO_WR   = 3'd6
    } bus_kind_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_MEM_RD = 2'd0,
        CLS_MEM_WR = 2'd1,
        CLS_IO_RD  = 2'd2,
        CLS_IO_WR  = 2'd3
    } acc_class_e;

    typedef struct packed {
        logic m1_n;
        logic rd_n;
        logic wr_n;
        logic mreq_n;
        logic iorq_n;
    } strobes_t;

    // Memory request wins over I/O request; inside each group the order
    // of the checks below is the priority.
    function automatic bus_kind_e decode_strobes(strobes_t s);
        bus_kind_e k;
        k = KIND_NONE;
        if (!s.mreq_n) begin
            if (!s.rd_n)      k = s.m1_n ? KIND_MEM_RD : KIND_FETCH;
            else if (!s.wr_n) k = KIND_MEM_WR;
        end else if (!s.iorq_n) begin
            if (!s.m1_n)      k = KIND_INT_ACK;
            else if (!s.rd_n) k = KIND_IO_RD;
            else if (!s.wr_n) k = KIND_IO_WR;
        end
        return k;
    endfunction

    // Fetch folds into memory read, interrupt acknowledge into I/O read.
    function automatic acc_class_e kind_to_class(bus_kind_e k);
        acc_class_e c;
        case (k)
            KIND_MEM_WR:  c = CLS_MEM_WR;
            KIND_INT_ACK: c = CLS_IO_RD;
            KIND_IO_RD:   c = CLS_IO_RD;
            KIND_IO_WR:   c = CLS_IO_WR;
            default:      c = CLS_MEM_RD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/busmon_decode.sv
module busmon_decode
    import busmon_pkg::*;
(
    input  strobes_t  strb,
    output bus_kind_e kind
);

    always_comb begin
        kind = decode_strobes(strb);
    end

endmodule

// File: rtl/busmon_tracker.sv
module busmon_tracker
    import busmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      smp_en,
    input  bus_kind_e cur_kind,
    output bus_kind_e prev_kind,
    output logic      open_c,
    output logic      close_c,
    output logic      clash_c,
    output logic      start_o,
    output logic      end_o,
    output logic      illegal_o
);

    bus_kind_e prev_q;
    logic      changed;
    logic      prev_active;
    logic      cur_active;

    always_comb begin
        prev_active = (prev_q != KIND_NONE);
        cur_active  = (cur_kind != KIND_NONE);
        changed     = smp_en && (cur_kind != prev_q);
        open_c      = changed && !prev_active;
        close_c     = changed && prev_active && !cur_active;
        clash_c     = changed && prev_active && cur_active;
    end

    assign prev_kind = prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= KIND_NONE;
            start_o   <= 1'b0;
            end_o     <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            if (smp_en) prev_q <= cur_kind;
            start_o   <= open_c;
            end_o     <= close_c;
            illegal_o <= clash_c;
        end
    end

    AST_ONE_MARK: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_o, end_o, illegal_o})); // R5

    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        start_o |-> (prev_q != KIND_NONE)); // R5

    AST_QUIET_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> !(start_o || end_o || illegal_o)); // R10

    AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(prev_q)); // R10

endmodule

// File: rtl/busmon_capture.sv
module busmon_capture
    import busmon_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_en,
    input  bus_kind_e         cur_kind,
    input  bus_kind_e         prev_kind,
    input  logic              open_c,
    input  logic              close_c,
    input  logic              clash_c,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ev_valid,
    output bus_kind_e         ev_kind,
    output acc_class_e        ev_class,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] ev_data
);

    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            ev_valid <= 1'b0;
            ev_kind  <= KIND_NONE;
            ev_class <= CLS_MEM_RD;
            ev_addr  <= '0;
            ev_data  <= '0;
        end else begin
            ev_valid <= 1'b0;
            if (smp_en && (cur_kind != KIND_NONE)) data_q <= data_i;
            if (open_c) begin
                addr_q <= addr_i;
                pend_q <= 1'b1;
            end
            if (clash_c) pend_q <= 1'b0;
            if (close_c) begin
                pend_q <= 1'b0;
                if (pend_q) begin
                    ev_valid <= 1'b1;
                    ev_kind  <= prev_kind;
                    ev_class <= kind_to_class(prev_kind);
                    ev_addr  <= addr_q;
                    ev_data  <= data_q;
                end
            end
        end
    end

    AST_EV_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> !ev_valid); // R7

    AST_EV_KIND_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (ev_kind != KIND_NONE)); // R7

    AST_FETCH_AS_READ: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == KIND_FETCH) |-> (ev_class == CLS_MEM_RD)); // R9

    AST_IACK_AS_IORD: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == KIND_INT_ACK) |-> (ev_class == CLS_IO_RD)); // R9

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(data_q)); // R10

endmodule

// File: rtl/bus_cycle_monitor.sv
module bus_cycle_monitor
    import busmon_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_en,
    input  logic                m1_n,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic                mreq_n,
    input  logic                iorq_n,
    input  logic [DATA_W-1:0]   data_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                cyc_start_o,
    output logic                cyc_end_o,
    output logic                illegal_o,
    output logic                ev_valid_o,
    output logic [KIND_W-1:0]   ev_kind_o,
    output logic [CLASS_W-1:0]  ev_class_o,
    output logic [ADDR_W-1:0]   ev_addr_o,
    output logic [DATA_W-1:0]   ev_data_o
);

    strobes_t   strb;
    bus_kind_e  cur_kind;
    bus_kind_e  prev_kind;
    logic       open_c;
    logic       close_c;
    logic       clash_c;
    bus_kind_e  ev_kind;
    acc_class_e ev_class;

    assign strb = '{m1_n: m1_n, rd_n: rd_n, wr_n: wr_n,
                    mreq_n: mreq_n, iorq_n: iorq_n};

    busmon_decode u_decode (
        .strb (strb),
        .kind (cur_kind)
    );

    busmon_tracker u_tracker (
        .clk       (clk),
        .rst       (rst),
        .smp_en    (smp_en),
        .cur_kind  (cur_kind),
        .prev_kind (prev_kind),
        .open_c    (open_c),
        .close_c   (close_c),
        .clash_c   (clash_c),
        .start_o   (cyc_start_o),
        .end_o     (cyc_end_o),
        .illegal_o (illegal_o)
    );

    busmon_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .smp_en    (smp_en),
        .cur_kind  (cur_kind),
        .prev_kind (prev_kind),
        .open_c    (open_c),
        .close_c   (close_c),
        .clash_c   (clash_c),
        .addr_i    (addr_i),
        .data_i    (data_i),
        .ev_valid  (ev_valid_o),
        .ev_kind   (ev_kind),
        .ev_class  (ev_class),
        .ev_addr   (ev_addr_o),
        .ev_data   (ev_data_o)
    );

    assign ev_kind_o  = ev_kind;
    assign ev_class_o = ev_class;

    AST_EV_WITH_END: assert property (@(posedge clk) disable iff (rst)
        ev_valid_o |-> cyc_end_o); // R7

    AST_ILLEGAL_NO_EV: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !ev_valid_o); // R8

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(ev_valid_o || cyc_start_o || cyc_end_o || illegal_o)); // R1

endmodule

// File: tb/sim_bus_cycle_monitor.sv
`timescale 1ns/1ps
module sim_bus_cycle_monitor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_en = 1'b0;
    logic [4:0]  strb = 5'b11111;   // {m1_n, rd_n, wr_n, mreq_n, iorq_n}
    logic [7:0]  data_i = 8'h00;
    logic [15:0] addr_i = 16'h0000;
    logic        cyc_start_o, cyc_end_o, illegal_o, ev_valid_o;
    logic [2:0]  ev_kind_o;
    logic [1:0]  ev_class_o;
    logic [15:0] ev_addr_o;
    logic [7:0]  ev_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_cycle_monitor u0 (
        .clk (clk), .rst (rst), .smp_en (smp_en),
        .m1_n (strb[4]), .rd_n (strb[3]), .wr_n (strb[2]),
        .mreq_n (strb[1]), .iorq_n (strb[0]),
        .data_i (data_i), .addr_i (addr_i),
        .cyc_start_o (cyc_start_o), .cyc_end_o (cyc_end_o),
        .illegal_o (illegal_o), .ev_valid_o (ev_valid_o),
        .ev_kind_o (ev_kind_o), .ev_class_o (ev_class_o),
        .ev_addr_o (ev_addr_o), .ev_data_o (ev_data_o)
    );

    // Layout: strb[61:57] din[56:49] ain[48:33] marks{start,end,ill,ev}[32:29]
    //         kind[28:26] class[25:24] eaddr[23:8] edata[7:0]
    localparam int NV = 23;
    localparam logic [61:0] VEC [0:NV-1] = '{
        {5'b11111, 8'h00, 16'h0000, 4'b0000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R4 idle
        {5'b00101, 8'h3E, 16'h1234, 4'b1000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R2 fetch opens, R5
        {5'b00101, 8'h3F, 16'h9999, 4'b0000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R5 addr ignored, R6
        {5'b11111, 8'hEE, 16'h0000, 4'b0101, 3'd1, 2'd0, 16'h1234, 8'h3F}, // R7 R9 R6
        {5'b11001, 8'hAA, 16'h8000, 4'b1000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R2 mem write
        {5'b11111, 8'h00, 16'h0000, 4'b0101, 3'd3, 2'd1, 16'h8000, 8'hAA}, // R9
        {5'b00110, 8'hFF, 16'h0038, 4'b1000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R3 ack beats read
        {5'b11111, 8'h00, 16'h0000, 4'b0101, 3'd4, 2'd2, 16'h0038, 8'hFF}, // R9 ack as io read
        {5'b10110, 8'h55, 16'h00FE, 4'b1000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R3 io read
        {5'b11111, 8'h00, 16'h0000, 4'b0101, 3'd5, 2'd2, 16'h00FE, 8'h55},
        {5'b11010, 8'h77, 16'h0010, 4'b1000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R3 io write
        {5'b11111, 8'h00, 16'h0000, 4'b0101, 3'd6, 2'd3, 16'h0010, 8'h77},
        {5'b10100, 8'h12, 16'h4000, 4'b1000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R4 mem before io
        {5'b11111, 8'h00, 16'h0000, 4'b0101, 3'd2, 2'd0, 16'h4000, 8'h12},
        {5'b10101, 8'h01, 16'h5000, 4'b1000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R2 mem read
        {5'b11001, 8'h02, 16'h5001, 4'b0010, 3'd0, 2'd0, 16'h0000, 8'h00}, // R8 read->write
        {5'b11111, 8'h00, 16'h0000, 4'b0100, 3'd0, 2'd0, 16'h0000, 8'h00}, // R8 no event
        {5'b10001, 8'h21, 16'h6000, 4'b1000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R2 read over write
        {5'b11111, 8'h00, 16'h0000, 4'b0101, 3'd2, 2'd0, 16'h6000, 8'h21},
        {5'b11101, 8'h00, 16'h0000, 4'b0000, 3'd0, 2'd0, 16'h0000, 8'h00}, // R4 bare request
        {5'b00101, 8'h00, 16'hA000, 4'b1000, 3'd0, 2'd0, 16'h0000, 8'h00},
        {5'b00110, 8'h00, 16'hA001, 4'b0010, 3'd0, 2'd0, 16'h0000, 8'h00}, // R8 fetch->ack
        {5'b11111, 8'h00, 16'h0000, 4'b0100, 3'd0, 2'd0, 16'h0000, 8'h00}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic marks(input string req, input logic [3:0] exp);
        chk(req, "markers{start,end,ill,ev}",
            {28'd0, cyc_start_o, cyc_end_o, illegal_o, ev_valid_o}, {28'd0, exp});
    endtask

    task automatic step(input logic en, input logic [4:0] s,
                        input logic [7:0] d, input logic [15:0] a);
        smp_en = en; strb = s; data_i = d; addr_i = a;
        @(negedge clk);   // R11: results visible after the sampling edge
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        marks("R1", 4'b0000);
        chk("R1", "ev_kind", {29'd0, ev_kind_o}, 32'd0);
        chk("R1", "ev_addr", {16'd0, ev_addr_o}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][61:57], VEC[i][56:49], VEC[i][48:33]);
            marks("R2 R3 R4 R5 R8 R11", VEC[i][32:29]);
            if (VEC[i][29]) begin
                chk("R7", "ev_kind",  {29'd0, ev_kind_o},  {29'd0, VEC[i][28:26]});
                chk("R9", "ev_class", {30'd0, ev_class_o}, {30'd0, VEC[i][25:24]});
                chk("R5", "ev_addr",  {16'd0, ev_addr_o},  {16'd0, VEC[i][23:8]});
                chk("R6", "ev_data",  {24'd0, ev_data_o},  {24'd0, VEC[i][7:0]});
            end
        end

        // R10: disabled clocks take no sample
        step(1'b1, 5'b10101, 8'h10, 16'h7000);
        marks("R10", 4'b1000);
        step(1'b0, 5'b11111, 8'h99, 16'h0000);
        marks("R10", 4'b0000);
        step(1'b0, 5'b11001, 8'h98, 16'h0001);
        marks("R10", 4'b0000);
        step(1'b1, 5'b10101, 8'h20, 16'h7777);
        marks("R10", 4'b0000);
        step(1'b1, 5'b11111, 8'h00, 16'h0000);
        marks("R10", 4'b0101);
        chk("R10", "ev_addr", {16'd0, ev_addr_o}, 32'h7000);
        chk("R10", "ev_data", {24'd0, ev_data_o}, 32'h20);
        step(1'b0, 5'b11111, 8'h00, 16'h0000);
        marks("R7", 4'b0000);

        // R1: reset while a cycle is open drops it
        step(1'b1, 5'b10110, 8'h44, 16'h0080);
        marks("R1", 4'b1000);
        rst = 1'b1;
        step(1'b1, 5'b10110, 8'h45, 16'h0080);
        marks("R1", 4'b0000);
        rst = 1'b0;
        step(1'b1, 5'b11111, 8'h00, 16'h0000);
        marks("R1", 4'b0000);
        step(1'b1, 5'b10110, 8'h46, 16'h0090);
        marks("R1", 4'b1000);
        step(1'b1, 5'b11111, 8'h00, 16'h0000);
        marks("R1", 4'b0101);
        chk("R1", "ev_addr", {16'd0, ev_addr_o}, 32'h0090);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule